// File: doc/BRIEF.md
# PWM Channel with Down-Counter and Compare

One pulse-width channel, stepped by a tick enable from an external prescaler. It holds a period reload value and a compare value, both written through a saturating 32-bit write port. It takes its control nibble (enable, invert, mode) from a shared control word that the channel's own index selects. The counter runs down from the reload value to zero and then wraps, so one period lasts reload + 1 ticks. The output is active for the first compare + 1 ticks of each period. Two boundary rules decide the duty outright. A zero reload gives a constantly inactive output. A compare at or above a nonzero reload gives a constantly active output.

In toggle mode the channel repeats periods for as long as it is enabled. In one-shot mode it runs a single period and then parks at the inactive level until the enable is dropped and raised again. The invert bit acts on the output at once and never restarts the count. The live counter value can be read back, and a write aimed at it changes nothing. A one-cycle pulse marks each wrap.

Top module: `pwm_channel`

## Requirements
- R1: After reset, reload_rd, compare_rd, cnt_snap, period_end and pwm_out are all zero, with the control word at zero.
- R2: A write whose data is above 65535 stores 65535. Smaller values are stored unchanged. wr_sel 1 selects the reload value and wr_sel 2 selects the compare value, and each can be read back on the next cycle.
- R3: A write with wr_sel 3 targets the counter snapshot and has no effect on cnt_snap or on any other output.
- R4: While running, each tick decrements the counter. A tick with the counter at zero reloads it, and period_end is high for exactly the following cycle. One period is therefore reload + 1 ticks.
- R5: With 0 < compare < reload, the output is active while the counter is at or above reload − compare. That gives compare + 1 active ticks in each period.
- R6: When reload is 0, the output never goes active: it stays at the inactive level, which is 0, or 1 when inverted.
- R7: When reload is nonzero and compare ≥ reload, a running channel's output is constantly active.
- R8: With enable (nibble bit 0) clear, the output is 0, or 1 when invert (nibble bit 2) is set. The counter holds at the reload value.
- R9: A change of invert while running flips pwm_out in the same cycle and leaves the counter sequence untouched.
- R10: With mode (nibble bit 3) clear, the channel runs one period, raises period_end once and then stays inactive until enable has been low for at least one clock.
- R11: The channel reads its nibble only at bit offset 0 for index 0, and at offset 4 + 4·index for indexes 1 to 3. Bits elsewhere in the control word have no effect.
- R12: With tick low, a running counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from the prescaler |
| ctrl_word | input | 32 | Shared control word; the nibble for this channel is selected by CHAN_IDX |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 1 reload, 2 compare, 3 snapshot (ignored), 0 none |
| wr_data | input | 32 | Write data, saturated to 16 bits |
| reload_rd | output | 16 | Stored period reload value |
| compare_rd | output | 16 | Stored compare value |
| cnt_snap | output | 16 | Current counter value (read-only) |
| pwm_out | output | 1 | Output level |
| period_end | output | 1 | One-cycle pulse after each wrap |

## Verification
A written value shows on reload_rd and compare_rd one clock after its write strobe. A counter step from a tick shows on cnt_snap one clock after that tick. period_end rises in the same cycle that cnt_snap shows the reloaded value. pwm_out follows the registered counter and the live control inputs without a further register, so enable and invert take effect in the cycle they change. The reference model updates at each rising edge from the inputs held across that edge. Outputs are compared one nanosecond after the edge, before the stimulus moves on, so every expected value is sampled in the cycle it is due.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int NIB_W    = 4;
    localparam int CTL_EN   = 0;
    localparam int CTL_INV  = 2;
    localparam int CTL_MODE = 3;

    localparam logic [1:0] SEL_NONE    = 2'd0;
    localparam logic [1:0] SEL_RELOAD  = 2'd1;
    localparam logic [1:0] SEL_COMPARE = 2'd2;
    localparam logic [1:0] SEL_SNAP    = 2'd3;

    typedef struct packed {
        logic en;
        logic inv;
        logic mode;   // 1 = repeating, 0 = single period
    } chan_ctrl_t;

    // Bit offset of a channel's nibble inside the shared control word.
    function automatic int nibble_offset(input int idx);
        return (idx == 0) ? 0 : (NIB_W + NIB_W * idx);
    endfunction

endpackage

// File: rtl/pwm_ctrl_decode.sv
module pwm_ctrl_decode
    import pwm_pkg::*;
#(
    parameter int BUS_W    = 32,
    parameter int CHAN_IDX = 0
) (
    input  logic [BUS_W-1:0] ctrl_word,
    output chan_ctrl_t       ctl
);
    localparam int OFF = nibble_offset(CHAN_IDX);

    logic [NIB_W-1:0] nib;
    logic             unused_bits;

    generate
        if (OFF + NIB_W <= BUS_W) begin : g_slice
            assign nib = ctrl_word[OFF +: NIB_W];
        end else begin : g_none
            assign nib = '0;
        end
    endgenerate

    assign unused_bits = ^ctrl_word;

    always_comb begin
        ctl.en   = nib[CTL_EN];
        ctl.inv  = nib[CTL_INV];
        ctl.mode = nib[CTL_MODE];
    end
endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [BUS_W-1:0] wr_data,
    output logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] compare_q
);
    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] compare;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [CNT_W-1:0] sat_val;

    generate
        if (BUS_W > CNT_W) begin : g_clamp
            logic over;
            assign over    = |wr_data[BUS_W-1:CNT_W];
            assign sat_val = over ? {CNT_W{1'b1}} : wr_data[CNT_W-1:0];
        end else begin : g_pass
            assign sat_val = wr_data[CNT_W-1:0];
        end
    endgenerate

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_RELOAD:  cfg_d.reload  = sat_val;
                SEL_COMPARE: cfg_d.compare = sat_val;
                default:     cfg_d = cfg_q;   // snapshot target is read-only
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign reload_q  = cfg_q.reload;
    assign compare_q = cfg_q.compare;
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  chan_ctrl_t       ctl,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             period_end
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             pe;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic run;

    assign run = ctl.en && !ctr_q.done;

    always_comb begin
        ctr_d    = ctr_q;
        ctr_d.pe = 1'b0;
        if (!ctl.en) ctr_d.done = 1'b0;
        if (!run) begin
            ctr_d.cnt = reload;
        end else if (tick) begin
            if (ctr_q.cnt == '0) begin
                ctr_d.cnt = reload;
                ctr_d.pe  = 1'b1;
                if (!ctl.mode) ctr_d.done = 1'b1;
            end else begin
                ctr_d.cnt = ctr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign cnt        = ctr_q.cnt;
    assign running    = run;
    assign period_end = ctr_q.pe;
endmodule

// File: rtl/pwm_duty.sv
module pwm_duty #(
    parameter int CNT_W = 16
) (
    input  logic             running,
    input  logic             inv,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] compare,
    output logic             pwm_out
);
    logic active;

    always_comb begin
        if (reload == '0)            active = 1'b0;
        else if (compare >= reload)  active = 1'b1;
        else                         active = (cnt >= (reload - compare));
        pwm_out = (running && active) ^ inv;
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int BUS_W    = 32,
    parameter int CHAN_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [BUS_W-1:0] ctrl_word,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [BUS_W-1:0] wr_data,
    output logic [CNT_W-1:0] reload_rd,
    output logic [CNT_W-1:0] compare_rd,
    output logic [CNT_W-1:0] cnt_snap,
    output logic             pwm_out,
    output logic             period_end
);
    chan_ctrl_t ctl;
    logic       run;

    pwm_ctrl_decode #(.BUS_W(BUS_W), .CHAN_IDX(CHAN_IDX)) u_dec (
        .ctrl_word (ctrl_word),
        .ctl       (ctl)
    );

    pwm_cfg_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .reload_q  (reload_rd),
        .compare_q (compare_rd)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .ctl        (ctl),
        .reload     (reload_rd),
        .cnt        (cnt_snap),
        .running    (run),
        .period_end (period_end)
    );

    pwm_duty #(.CNT_W(CNT_W)) u_duty (
        .running (run),
        .inv     (ctl.inv),
        .cnt     (cnt_snap),
        .reload  (reload_rd),
        .compare (compare_rd),
        .pwm_out (pwm_out)
    );
endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk #(
    parameter int CNT_W = 16,
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [BUS_W-1:0] wr_data,
    input logic             en,
    input logic             inv,
    input logic             run,
    input logic [CNT_W-1:0] reload_rd,
    input logic [CNT_W-1:0] compare_rd,
    input logic [CNT_W-1:0] cnt_snap,
    input logic             pwm_out
);
    localparam logic [BUS_W-1:0] MAXV = BUS_W'((64'd1 << CNT_W) - 64'd1);

    a_r2_reload_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1) |=>
            ((BUS_W'(reload_rd)) == (($past(wr_data) > MAXV) ? MAXV : $past(wr_data))));

    a_r6_zero_reload_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_rd == '0) |-> (pwm_out == inv));

    a_r7_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (run && reload_rd != '0 && compare_rd >= reload_rd) |-> (pwm_out != inv));

    a_r8_disabled_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |-> (pwm_out == inv));

    a_r12_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt_snap));
endmodule

bind pwm_channel pwm_channel_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .en         (ctl.en),
    .inv        (ctl.inv),
    .run        (run),
    .reload_rd  (reload_rd),
    .compare_rd (compare_rd),
    .cnt_snap   (cnt_snap),
    .pwm_out    (pwm_out)
);

// File: tb/sim_pwm_channel.sv
`timescale 1ns/1ps
module sim_pwm_channel;
    localparam int IDX = 2;
    localparam int OFF = 12;   // nibble offset for index 2 (R11)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [31:0] ctrl_word;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [15:0] reload_rd, compare_rd, cnt_snap;
    logic        pwm_out, period_end;

    logic        b_en = 1'b0, b_inv = 1'b0, b_mode = 1'b0;
    logic [31:0] b_noise = 32'd0;

    integer checks = 0, fails = 0;
    string  tag = "R1";
    bit     finished = 0;

    // reference model state
    integer m_rel = 0, m_cmp = 0, m_cnt = 0;
    bit     m_done = 0, m_pe = 0;

    always #2 clk = ~clk;

    assign ctrl_word = ({28'd0, b_mode, b_inv, 1'b0, b_en} << OFF) | b_noise;

    pwm_channel #(.CNT_W(16), .BUS_W(32), .CHAN_IDX(IDX)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_word(ctrl_word),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .reload_rd(reload_rd), .compare_rd(compare_rd), .cnt_snap(cnt_snap),
        .pwm_out(pwm_out), .period_end(period_end)
    );

    function automatic integer clamp(input logic [31:0] v);
        return (v > 32'd65535) ? 65535 : int'(v);
    endfunction

    always @(posedge clk) begin
        integer old_rel;
        bit     live;
        old_rel = m_rel;
        if (!rst_n) begin
            m_rel = 0; m_cmp = 0; m_cnt = 0; m_done = 0; m_pe = 0;
        end else begin
            live = b_en && !m_done;
            m_pe = 0;
            if (wr_en && wr_sel == 2'd1) m_rel = clamp(wr_data);
            if (wr_en && wr_sel == 2'd2) m_cmp = clamp(wr_data);
            if (!b_en) m_done = 0;
            if (!live) m_cnt = old_rel;
            else if (tick) begin
                if (m_cnt == 0) begin
                    m_cnt = old_rel; m_pe = 1;
                    if (!b_mode) m_done = 1;
                end else m_cnt = m_cnt - 1;
            end
        end
    end

    function automatic bit exp_pwm();
        bit act, live;
        live = b_en && !m_done;
        if (m_rel == 0)          act = 0;
        else if (m_cmp >= m_rel) act = 1;
        else                     act = ((m_rel - m_cnt) <= m_cmp);
        return (live && act) ^ b_inv;
    endfunction

    task automatic chk(input string t, input string what, input integer act, input integer exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        if (rst_n) begin
            chk(tag, "cnt_snap", int'(cnt_snap), m_cnt);
            chk(tag, "period_end", int'(period_end), int'(m_pe));
            chk(tag, "pwm_out", int'(pwm_out), int'(exp_pwm()));
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        cyc();
        wr_en = 1'b0; wr_sel = 2'd0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        integer act_n, pe_n;
        logic [15:0] held;
        logic        lvl;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        tag = "R1";
        chk("R1", "reload_rd", int'(reload_rd), 0);
        chk("R1", "compare_rd", int'(compare_rd), 0);
        chk("R1", "cnt_snap", int'(cnt_snap), 0);
        chk("R1", "pwm_out", int'(pwm_out), 0);
        chk("R1", "period_end", int'(period_end), 0);

        tag = "R2";
        wr(2'd1, 32'h0001_2345);
        chk("R2", "reload saturated", int'(reload_rd), 65535);
        wr(2'd2, 32'd70000);
        chk("R2", "compare saturated", int'(compare_rd), 65535);
        wr(2'd1, 32'd65535);
        chk("R2", "reload max", int'(reload_rd), 65535);
        wr(2'd1, 32'd9);
        chk("R2", "reload plain", int'(reload_rd), 9);
        wr(2'd2, 32'd3);
        chk("R2", "compare plain", int'(compare_rd), 3);
        cyc();

        tag = "R3";
        wr(2'd3, 32'h0000_0055);
        cyc();
        chk("R3", "snapshot write ignored", int'(cnt_snap), 9);
        chk("R3", "reload untouched", int'(reload_rd), 9);
        chk("R3", "compare untouched", int'(compare_rd), 3);

        tag = "R11";
        b_noise = 32'h0000_0009;   // enable+mode at another channel's offset
        tick = 1'b1;
        repeat (8) cyc();
        chk("R11", "foreign nibble ignored cnt", int'(cnt_snap), 9);
        chk("R11", "foreign nibble ignored pwm", int'(pwm_out), 0);
        b_noise = 32'h0;
        tick = 1'b0;
        cyc();

        tag = "R5";
        b_en = 1'b1; b_mode = 1'b1; tick = 1'b1;
        act_n = 0; pe_n = 0;
        for (int i = 0; i < 30; i++) begin
            cyc();
            act_n += pwm_out;
            pe_n  += period_end;
        end
        chk("R5", "active samples in 30 ticks", act_n, 12);
        chk("R4", "period_end pulses in 30 ticks", pe_n, 3);

        tag = "R12";
        tick = 1'b0;
        cyc();
        held = cnt_snap;
        repeat (5) cyc();
        chk("R12", "counter held without tick", int'(cnt_snap), int'(held));

        tag = "R9";
        lvl = pwm_out;
        b_inv = 1'b1;
        #1;
        chk("R9", "invert immediate", int'(pwm_out), int'(!lvl));
        chk("R9", "counter not restarted", int'(cnt_snap), int'(held));
        tick = 1'b1;
        repeat (12) cyc();
        b_inv = 1'b0;
        cyc();

        tag = "R4";
        tick = 1'b0;
        repeat (2) begin cyc(); tick = ~tick; end
        for (int i = 0; i < 20; i++) begin tick = i[0]; cyc(); end

        tag = "R6";
        wr(2'd1, 32'd0);
        tick = 1'b1;
        act_n = 0;
        for (int i = 0; i < 15; i++) begin cyc(); act_n += pwm_out; end
        chk("R6", "zero reload never active", act_n, 0);

        tag = "R7";
        wr(2'd1, 32'd5);
        wr(2'd2, 32'd5);
        act_n = 0;
        for (int i = 0; i < 12; i++) begin cyc(); act_n += pwm_out; end
        chk("R7", "compare equal reload full duty", act_n, 12);
        wr(2'd2, 32'd7);
        act_n = 0;
        for (int i = 0; i < 12; i++) begin cyc(); act_n += pwm_out; end
        chk("R7", "compare above reload full duty", act_n, 12);

        tag = "R8";
        b_en = 1'b0;
        cyc();
        chk("R8", "disabled level", int'(pwm_out), 0);
        chk("R8", "disabled counter at reload", int'(cnt_snap), 5);
        b_inv = 1'b1;
        #1;
        chk("R8", "disabled inverted level", int'(pwm_out), 1);
        cyc();
        b_inv = 1'b0;

        tag = "R10";
        wr(2'd1, 32'd3);
        wr(2'd2, 32'd1);
        cyc();
        b_en = 1'b1; b_mode = 1'b0;
        pe_n = 0;
        for (int i = 0; i < 15; i++) begin cyc(); pe_n += period_end; end
        chk("R10", "single pulse in one-shot", pe_n, 1);
        chk("R10", "parked inactive", int'(pwm_out), 0);
        b_en = 1'b0;
        cyc();
        b_en = 1'b1;
        pe_n = 0;
        for (int i = 0; i < 10; i++) begin cyc(); pe_n += period_end; end
        chk("R10", "re-enable runs again", pe_n, 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule